// File: doc/BRIEF.md
# Receive Interrupt Mode Controller

This block decides when a serial receiver raises an interrupt request and which status code it reports to the interrupt vector. Every time the deserializer hands over a character, it sends a one-cycle strobe with that character's error flags. The controller sorts each character into one of two classes: an ordinary character, or a special receive condition. It then applies the receive interrupt mode selected in a control register, and either sets a pending request or ignores the character.

There are four modes: no receive interrupts, an interrupt on every character, an interrupt on the first character only, and an interrupt on special conditions only. The first-character and special-only modes suit block transfers, where a CPU or DMA engine moves the data and only exceptional events need attention. After the first character has been reported in first-character mode, ordinary characters stay silent until software writes a re-arm command. Special conditions still interrupt at any time. The pending request stays up until the interrupt acknowledge.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset, `irq_pend` is 0, `vec_status` is 2'b00 (no request), and first-character detection is armed.
- R2: With `irq_mode` = 2'b00 (disabled), no character raises a request, whatever its error flags.
- R3: With `irq_mode` = 2'b10, every strobed character raises `irq_pend` in the cycle after the strobe. A character with no special condition reports `vec_status` = 2'b01 (character available).
- R4: A special condition reports `vec_status` = 2'b10. Overrun is always special. Framing error is special only when `framed_mode` = 0. End-of-frame is special only when `framed_mode` = 1. Otherwise each of these flags is ignored.
- R5: A parity error is a special condition only when `parity_special_en` = 1. When it is 0, the parity error is ignored and the character reports 2'b01.
- R6: With `irq_mode` = 2'b01, the first character after arming raises a request. Ordinary characters after that raise nothing.
- R7: With `irq_mode` = 2'b01, special conditions raise a request at any time after the first character.
- R8: A one-cycle `rearm_cmd` arms first-character detection again, so the next ordinary character in mode 2'b01 raises a request.
- R9: With `irq_mode` = 2'b11, ordinary characters raise nothing and special conditions raise a request with status 2'b10.
- R10: Special status has priority. A character carrying a special condition reports 2'b10. While a request is pending, a special condition upgrades the status from 2'b01 to 2'b10, and an ordinary character never downgrades it from 2'b10 to 2'b01.
- R11: `irq_pend` stays asserted until `irq_ack`. In the cycle after the acknowledge it is 0 and `vec_status` is 2'b00, unless a new request arrives in the same cycle as the acknowledge. That new request wins and reports its own status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | One-cycle pulse per received character |
| err_overrun | input | 1 | Receiver overrun flag for this character |
| err_framing | input | 1 | Framing error flag for this character |
| err_parity | input | 1 | Parity error flag for this character |
| err_eof | input | 1 | End-of-frame flag for this character |
| framed_mode | input | 1 | 0 = asynchronous line, 1 = bit-oriented framed line |
| parity_special_en | input | 1 | Treat a parity error as a special condition |
| irq_mode | input | 2 | Receive interrupt mode (00 off, 01 first char, 10 every char, 11 special only) |
| irq_ack | input | 1 | Interrupt acknowledge, clears the pending request |
| rearm_cmd | input | 1 | Re-arm first-character detection |
| irq_pend | output | 1 | Pending receive interrupt request |
| vec_status | output | 2 | Vector status: 00 none, 01 character, 10 special condition |

## Verification
The assertions assume that the error flags matter only while `rx_strobe` is high. They also assume that `irq_mode` and `framed_mode` are steady in the cycle around each strobe. The properties about ack and hold therefore condition on the strobe being low. The bench changes the mode and line settings only at negative edges, between strobes, and every strobe lasts one cycle. Each acknowledge is given either alone or deliberately together with a strobe, so the arrival case is exercised on purpose.

// File: rtl/rxi_pkg.sv
package rxi_pkg;

  localparam int MODE_W = 2;
  localparam int STAT_W = 2;

  typedef enum logic [MODE_W-1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_EVERY = 2'b10,
    RXI_SPEC  = 2'b11
  } rxi_mode_e;

  typedef enum logic [STAT_W-1:0] {
    ST_NONE = 2'b00,
    ST_CHAR = 2'b01,
    ST_SPCL = 2'b10
  } rxi_stat_e;

endpackage

// File: rtl/rxi_cond_classify.sv
module rxi_cond_classify (
  input  logic strobe,
  input  logic ovr,
  input  logic frm,
  input  logic par,
  input  logic eof,
  input  logic framed,
  input  logic par_en,
  output logic special
);

  logic frm_hit;
  logic eof_hit;
  logic par_hit;

  always_comb begin
    frm_hit = frm & ~framed;
    eof_hit = eof & framed;
    par_hit = par & par_en;
    special = strobe & (ovr | frm_hit | eof_hit | par_hit);
  end

endmodule

// File: rtl/rxi_arm_track.sv
module rxi_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic first_mode,
  input  logic strobe,
  input  logic rearm,
  output logic armed
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = rearm | (first_mode & strobe);
    armed_d  = rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed = armed_q;

endmodule

// File: rtl/rxi_pend_reg.sv
module rxi_pend_reg
  import rxi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise,
  input  logic              raise_spcl,
  input  logic              ack,
  output logic              pend,
  output logic [STAT_W-1:0] status
);

  logic      pend_q, pend_d;
  rxi_stat_e stat_q, stat_d;
  logic      upd_en;
  rxi_stat_e new_stat;

  always_comb begin
    new_stat = raise_spcl ? ST_SPCL : ST_CHAR;
    upd_en   = raise | ack;
    pend_d   = pend_q;
    stat_d   = stat_q;
    if (raise) begin
      pend_d = 1'b1;
      if (ack || !pend_q || stat_q != ST_SPCL) stat_d = new_stat;
    end else if (ack) begin
      pend_d = 1'b0;
      stat_d = ST_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stat_q <= ST_NONE;
    end else if (upd_en) begin
      pend_q <= pend_d;
      stat_q <= stat_d;
    end
  end

  assign pend   = pend_q;
  assign status = stat_q;

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rxi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic              err_overrun,
  input  logic              err_framing,
  input  logic              err_parity,
  input  logic              err_eof,
  input  logic              framed_mode,
  input  logic              parity_special_en,
  input  logic [MODE_W-1:0] irq_mode,
  input  logic              irq_ack,
  input  logic              rearm_cmd,
  output logic              irq_pend,
  output logic [STAT_W-1:0] vec_status
);

  logic      special;
  logic      armed;
  logic      first_mode;
  logic      raise;
  rxi_mode_e mode;

  assign mode       = rxi_mode_e'(irq_mode);
  assign first_mode = (mode == RXI_FIRST);

  rxi_cond_classify u_cls (
    .strobe (rx_strobe),
    .ovr    (err_overrun),
    .frm    (err_framing),
    .par    (err_parity),
    .eof    (err_eof),
    .framed (framed_mode),
    .par_en (parity_special_en),
    .special(special)
  );

  rxi_arm_track u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_mode(first_mode),
    .strobe    (rx_strobe),
    .rearm     (rearm_cmd),
    .armed     (armed)
  );

  always_comb begin
    case (mode)
      RXI_FIRST: raise = rx_strobe & (armed | special);
      RXI_EVERY: raise = rx_strobe;
      RXI_SPEC:  raise = special;
      default:   raise = 1'b0;
    endcase
  end

  rxi_pend_reg u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (raise),
    .raise_spcl(special),
    .ack       (irq_ack),
    .pend      (irq_pend),
    .status    (vec_status)
  );

endmodule

// File: rtl/rxi_checker.sv
module rxi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_strobe,
  input logic       err_overrun,
  input logic [1:0] irq_mode,
  input logic       irq_ack,
  input logic       irq_pend,
  input logic [1:0] vec_status
);

  p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b00 && !irq_pend) |=> !irq_pend);

  p_every_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b10 && rx_strobe) |=> irq_pend);

  p_spec_only_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b11 && !rx_strobe && !irq_pend) |=> !irq_pend);

  p_ovr_special_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode != 2'b00 && rx_strobe && err_overrun) |=> vec_status == 2'b10);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);

  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !rx_strobe) |=> (!irq_pend && vec_status == 2'b00));

  p_stat_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |-> vec_status == 2'b00);

endmodule

bind rx_irq_ctrl rxi_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_strobe  (rx_strobe),
  .err_overrun(err_overrun),
  .irq_mode   (irq_mode),
  .irq_ack    (irq_ack),
  .irq_pend   (irq_pend),
  .vec_status (vec_status)
);

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic       rx_strobe, err_overrun, err_framing, err_parity, err_eof;
  logic       framed_mode, parity_special_en;
  logic [1:0] irq_mode;
  logic       irq_ack, rearm_cmd;
  logic       irq_pend;
  logic [1:0] vec_status;

  int checks = 0;
  int errors = 0;

  rx_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe),
    .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity), .err_eof(err_eof),
    .framed_mode(framed_mode), .parity_special_en(parity_special_en),
    .irq_mode(irq_mode), .irq_ack(irq_ack), .rearm_cmd(rearm_cmd),
    .irq_pend(irq_pend), .vec_status(vec_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pend,status} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic p, input logic [1:0] s);
    chk(req, {irq_pend, vec_status}, {p, s});
  endtask

  // flags: {ovr, frm, par, eof}
  task automatic send(input logic [3:0] f);
    @(negedge clk);
    rx_strobe = 1'b1;
    {err_overrun, err_framing, err_parity, err_eof} = f;
    @(negedge clk);
    rx_strobe = 1'b0;
    {err_overrun, err_framing, err_parity, err_eof} = 4'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk);
    rearm_cmd = 1'b1;
    @(negedge clk);
    rearm_cmd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rx_strobe = 0; err_overrun = 0; err_framing = 0; err_parity = 0; err_eof = 0;
    framed_mode = 0; parity_special_en = 0; irq_mode = 2'b00;
    irq_ack = 0; rearm_cmd = 0;
    repeat (3) @(negedge clk);
    expect_out("R1", 1'b0, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 1'b0, 2'b00);
  endtask

  task automatic t_disabled();
    irq_mode = 2'b00;
    send(4'b0000);
    expect_out("R2 clean", 1'b0, 2'b00);
    send(4'b1111);
    expect_out("R2 errors", 1'b0, 2'b00);
  endtask

  task automatic t_every();
    irq_mode = 2'b10;
    send(4'b0000);
    expect_out("R3 char", 1'b1, 2'b01);
    repeat (3) @(negedge clk);
    expect_out("R11 hold", 1'b1, 2'b01);
    ack();
    expect_out("R11 clear", 1'b0, 2'b00);
  endtask

  task automatic t_classify();
    irq_mode = 2'b10;
    framed_mode = 0;
    send(4'b0100);
    expect_out("R4 framing async", 1'b1, 2'b10);
    ack();
    send(4'b0001);
    expect_out("R4 eof ignored async", 1'b1, 2'b01);
    ack();
    framed_mode = 1;
    send(4'b0001);
    expect_out("R4 eof framed", 1'b1, 2'b10);
    ack();
    send(4'b0100);
    expect_out("R4 framing ignored framed", 1'b1, 2'b01);
    ack();
    send(4'b1000);
    expect_out("R4 overrun", 1'b1, 2'b10);
    ack();
    framed_mode = 0;
  endtask

  task automatic t_parity();
    irq_mode = 2'b10;
    parity_special_en = 0;
    send(4'b0010);
    expect_out("R5 parity off", 1'b1, 2'b01);
    ack();
    parity_special_en = 1;
    send(4'b0010);
    expect_out("R5 parity on", 1'b1, 2'b10);
    ack();
    parity_special_en = 0;
  endtask

  task automatic t_first();
    rearm();
    irq_mode = 2'b01;
    send(4'b0000);
    expect_out("R6 first", 1'b1, 2'b01);
    ack();
    send(4'b0000);
    expect_out("R6 later char", 1'b0, 2'b00);
    send(4'b1000);
    expect_out("R7 overrun after first", 1'b1, 2'b10);
    ack();
    send(4'b0100);
    expect_out("R7 framing after first", 1'b1, 2'b10);
    ack();
  endtask

  task automatic t_rearm();
    irq_mode = 2'b01;
    send(4'b0000);
    expect_out("R8 before rearm", 1'b0, 2'b00);
    rearm();
    send(4'b0000);
    expect_out("R8 after rearm", 1'b1, 2'b01);
    ack();
  endtask

  task automatic t_spec_only();
    irq_mode = 2'b11;
    send(4'b0000);
    expect_out("R9 char ignored", 1'b0, 2'b00);
    send(4'b1000);
    expect_out("R9 special", 1'b1, 2'b10);
    ack();
  endtask

  task automatic t_priority();
    irq_mode = 2'b10;
    send(4'b1010);
    expect_out("R10 mixed", 1'b1, 2'b10);
    ack();
    send(4'b0000);
    expect_out("R10 char", 1'b1, 2'b01);
    send(4'b1000);
    expect_out("R10 upgrade", 1'b1, 2'b10);
    send(4'b0000);
    expect_out("R10 no downgrade", 1'b1, 2'b10);
    // acknowledge together with a new ordinary character
    @(negedge clk);
    irq_ack = 1'b1; rx_strobe = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; rx_strobe = 1'b0;
    expect_out("R11 ack with arrival", 1'b1, 2'b01);
    ack();
    expect_out("R11 final clear", 1'b0, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_every();
    t_classify();
    t_parity();
    t_first();
    t_rearm();
    t_spec_only();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule